// File: doc/BRIEF.md
# Clock-Loss Limp-Home Controller

This block watches a reference clock from outside the chip and keeps the system clocked when that reference stops. It runs on an always-present backup clock. It sees the outside clock only as a one-cycle `extTick` pulse per edge, already brought into the backup domain. A gap timer counts backup cycles since the last tick. When the gap reaches a programmable timeout and monitoring is armed, the block treats the reference as lost. It then does one of two things: it moves the system clock onto the backup source and enters limp-home mode, or, when limp-home is forbidden, it raises a one-cycle clock-monitor reset request.

In limp-home mode a 13-bit counter counts reference ticks. When it reaches 4096 the reference is taken as healthy again, and the clock choice goes back under control of the live selection bits. If the reference goes quiet again for a full timeout before the count completes, the counter restarts from zero and limp-home continues. The PLL drives the system clock only while auto mode and PLL select are both set and the PLL reports lock. Software can therefore keep the PLL out of use after recovery by clearing PLL select while in limp-home.

Every source change passes through one cycle with all sources gated off. The encoding is 0 = oscillator, 1 = PLL, 2 = backup and 3 = all gated.

Top module: `limp_home_ctrl`

## Requirements
- R1: While reset is held, `sysSel` is 0 (oscillator), and `limpHome` and `clkMonRst` are 0.
- R2: With monitoring armed, a run of TIMEOUT consecutive backup cycles without `extTick` is a clock loss. With `fastMonEn` set, a run of TIMEOUT_FAST cycles is enough. On the edge that ends such a run, `limpHome` becomes 1. Shorter runs have no effect.
- R3: `monArmed` equals `monEn | fastMonEn | limpHome`. While it is 0, no gap length causes a loss.
- R4: If `noLimp` is 1 when a loss is detected, `clkMonRst` is 1 for exactly one cycle and `limpHome` stays 0.
- R5: `limpHome` stays 1 from entry until exit, including during source switching and PLL bit changes.
- R6: Counting the ticks seen in limp-home from 1, the 4096th tick clears `limpHome` on its edge. After 4095 ticks `limpHome` is still 1.
- R7: In limp-home, a gap of a full timeout clears the tick count, so 4096 further ticks are needed to exit.
- R8: A change of `sysSel` between two sources always passes through exactly one cycle at value 3.
- R9: Two cycles after entry into limp-home, `sysSel` is 2 (backup). It stays 2 until exit.
- R10: Outside limp-home, `sysSel` settles at 1 (PLL) when `pllAuto`, `pllSel` and `pllLock` are all 1, and at 0 otherwise. A `pllSel` cleared during limp-home therefore gives 0 after exit, and the PLL is never selected without lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backup clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extTick | input | 1 | One-cycle pulse per reference clock edge |
| monEn | input | 1 | Monitor enable, normal timeout |
| fastMonEn | input | 1 | Monitor enable, short timeout |
| pllAuto | input | 1 | PLL automatic engage mode |
| pllSel | input | 1 | PLL chosen as system source |
| noLimp | input | 1 | Forbid limp-home; request reset on loss |
| pllLock | input | 1 | PLL lock flag |
| sysSel | output | 2 | System clock source: 0 osc, 1 PLL, 2 backup, 3 gated |
| limpHome | output | 1 | High throughout limp-home |
| clkMonRst | output | 1 | One-cycle clock-monitor reset request |
| monArmed | output | 1 | Loss detector active |

## Verification
Loss detection and PLL engagement can land on the same cycle. The bench waits for the oscillator to be selected with auto and select set but no lock. It then raises `pllLock` in exactly the cycle that ends the timeout. The check is that `sysSel` goes from 3 straight to 2 and never shows 1. The bench also times the 4096th tick so that it ends limp-home while the PLL is locked, and checks that the system clock then passes through the gated state to the PLL.

// File: rtl/limp_pkg.sv
package limp_pkg;
  typedef enum logic [1:0] {
    SEL_OSC    = 2'd0,
    SEL_PLL    = 2'd1,
    SEL_BACKUP = 2'd2,
    SEL_OFF    = 2'd3
  } clkSel_e;

  typedef struct packed {
    logic enterLimp;
    logic exitLimp;
    logic gapClr;
    logic rstReq;
  } ctrlStrobe_t;
endpackage

// File: rtl/limp_ctrl.sv
module limp_ctrl
  import limp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        monEn,
  input  logic        fastMonEn,
  input  logic        noLimp,
  input  logic        lossNow,
  input  logic        countDone,
  output logic        inLimp,
  output logic        armed,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_RUN, ST_LIMP} state_e;
  state_e state;

  assign inLimp = (state == ST_LIMP);
  assign armed  = inLimp | monEn | fastMonEn;

  always_comb begin
    strobe           = '0;
    strobe.enterLimp = !inLimp && lossNow && !noLimp;
    strobe.rstReq    = !inLimp && lossNow && noLimp;
    strobe.gapClr    = inLimp && lossNow;
    strobe.exitLimp  = inLimp && countDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 state <= ST_RUN;
    else if (strobe.enterLimp) state <= ST_LIMP;
    else if (strobe.exitLimp)  state <= ST_RUN;
  end
endmodule

// File: rtl/limp_datapath.sv
module limp_datapath
  import limp_pkg::*;
#(
  parameter int TIMEOUT      = 16,
  parameter int TIMEOUT_FAST = 4,
  parameter int EXIT_COUNT   = 4096,
  parameter int CNT_W        = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extTick,
  input  logic        fastMonEn,
  input  logic        armed,
  input  logic        inLimp,
  input  logic        pllWant,
  input  logic        pllLock,
  input  ctrlStrobe_t strobe,
  output logic        lossNow,
  output logic        countDone,
  output logic        clkMonRst,
  output clkSel_e     sysSel
);
  localparam int GAP_W = $clog2(TIMEOUT + 2);
  localparam logic [GAP_W-1:0] LAST_SLOW = GAP_W'(TIMEOUT - 1);
  localparam logic [GAP_W-1:0] LAST_FAST = GAP_W'(TIMEOUT_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EXIT_COUNT - 1);

  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] gapLast;
  logic [CNT_W-1:0] edgeCnt;
  clkSel_e          target;

  // gap timer: backup cycles since the last reference tick, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= '0;
    else if (extTick)       gapCnt <= '0;
    else if (gapCnt != '1)  gapCnt <= gapCnt + 1'b1;
  end

  assign gapLast   = fastMonEn ? LAST_FAST : LAST_SLOW;
  assign lossNow   = armed && !extTick && (gapCnt == gapLast);
  assign countDone = inLimp && extTick && (edgeCnt == LAST_EDGE);

  // recovery tick counter, live only in limp-home
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (!inLimp || strobe.enterLimp || strobe.exitLimp || strobe.gapClr)
      edgeCnt <= '0;
    else if (extTick)
      edgeCnt <= edgeCnt + 1'b1;
  end

  always_comb begin
    if (inLimp)                 target = SEL_BACKUP;
    else if (pllWant && pllLock) target = SEL_PLL;
    else                        target = SEL_OSC;
  end

  // break-before-make: gate the old source for one cycle, then take the new
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sysSel <= SEL_OSC;
    else if (sysSel == SEL_OFF) sysSel <= target;
    else if (sysSel != target)  sysSel <= SEL_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkMonRst <= 1'b0;
    else       clkMonRst <= strobe.rstReq;
  end
endmodule

// File: rtl/limp_home_ctrl.sv
module limp_home_ctrl
  import limp_pkg::*;
#(
  parameter int TIMEOUT      = 16,
  parameter int TIMEOUT_FAST = 4,
  parameter int EXIT_COUNT   = 4096,
  parameter int CNT_W        = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extTick,
  input  logic       monEn,
  input  logic       fastMonEn,
  input  logic       pllAuto,
  input  logic       pllSel,
  input  logic       noLimp,
  input  logic       pllLock,
  output logic [1:0] sysSel,
  output logic       limpHome,
  output logic       clkMonRst,
  output logic       monArmed
);
  ctrlStrobe_t strobe;
  logic        lossNow, countDone, inLimp, armed;
  clkSel_e     selInt;

  limp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .monEn(monEn), .fastMonEn(fastMonEn),
    .noLimp(noLimp), .lossNow(lossNow), .countDone(countDone),
    .inLimp(inLimp), .armed(armed), .strobe(strobe)
  );

  limp_datapath #(
    .TIMEOUT(TIMEOUT), .TIMEOUT_FAST(TIMEOUT_FAST),
    .EXIT_COUNT(EXIT_COUNT), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extTick(extTick), .fastMonEn(fastMonEn),
    .armed(armed), .inLimp(inLimp), .pllWant(pllAuto & pllSel),
    .pllLock(pllLock), .strobe(strobe), .lossNow(lossNow),
    .countDone(countDone), .clkMonRst(clkMonRst), .sysSel(selInt)
  );

  assign sysSel   = selInt;
  assign limpHome = inLimp;
  assign monArmed = armed;
endmodule

// File: rtl/limp_checker.sv
module limp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       extTick,
  input logic       noLimp,
  input logic       pllLock,
  input logic [1:0] sysSel,
  input logic       limpHome,
  input logic       clkMonRst,
  input logic       monArmed
);
  a_r8_gated_between: assert property (@(posedge clk) disable iff (!rstN)
    (sysSel != 2'd3 && sysSel != $past(sysSel)) |-> $past(sysSel) == 2'd3);

  a_r10_pll_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    (sysSel == 2'd1) |-> $past(pllLock));

  a_r3_armed_in_limp: assert property (@(posedge clk) disable iff (!rstN)
    limpHome |-> monArmed);

  a_r4_req_without_limp: assert property (@(posedge clk) disable iff (!rstN)
    clkMonRst |-> !limpHome);

  a_r2_entry_on_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(limpHome) |-> (!$past(extTick) && !$past(noLimp)));

  a_r9_backup_held: assert property (@(posedge clk) disable iff (!rstN)
    (limpHome && $past(limpHome) && $past(limpHome, 2)) |-> sysSel == 2'd2);
endmodule

bind limp_home_ctrl limp_checker u_limpChk (
  .clk(clk), .rstN(rstN), .extTick(extTick), .noLimp(noLimp),
  .pllLock(pllLock), .sysSel(sysSel), .limpHome(limpHome),
  .clkMonRst(clkMonRst), .monArmed(monArmed)
);

// File: tb/limp_home_ctrl_bench.sv
`timescale 1ns/1ps
module limp_home_ctrl_bench;
  localparam int TO  = 8;
  localparam int TOF = 3;
  localparam int OSC = 0, PLL = 1, BACKUP = 2, OFF = 3;

  logic clk = 1'b0;
  logic rstN, extTick, monEn, fastMonEn, pllAuto, pllSel, noLimp, pllLock;
  logic [1:0] sysSel;
  logic limpHome, clkMonRst, monArmed;
  int vecs = 0;
  int fails = 0;

  always #4 clk = ~clk;

  limp_home_ctrl #(.TIMEOUT(TO), .TIMEOUT_FAST(TOF)) u_limp_home_ctrl (
    .clk(clk), .rstN(rstN), .extTick(extTick), .monEn(monEn),
    .fastMonEn(fastMonEn), .pllAuto(pllAuto), .pllSel(pllSel),
    .noLimp(noLimp), .pllLock(pllLock), .sysSel(sysSel),
    .limpHome(limpHome), .clkMonRst(clkMonRst), .monArmed(monArmed)
  );

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one backup cycle, return at the next falling edge
  task automatic step(input logic t);
    extTick = t;
    @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  // block is in limp-home with no tick counted yet
  task automatic recoverCheck(input int expSel);
    runTicks(4095);
    check("R6 still limp after 4095 ticks", limpHome, 1);
    step(1'b1);
    check("R6 exit on 4096th tick", limpHome, 0);
    check("R8 backup held at exit edge", sysSel, BACKUP);
    step(1'b1);
    check("R8 gated cycle after exit", sysSel, OFF);
    step(1'b1);
    check("R10 source after recovery", sysSel, expSel);
  endtask

  initial begin
    rstN = 1'b0; extTick = 1'b0; monEn = 1'b1; fastMonEn = 1'b0;
    pllAuto = 1'b0; pllSel = 1'b0; noLimp = 1'b0; pllLock = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sysSel in reset", sysSel, OSC);
    check("R1 limpHome in reset", limpHome, 0);
    check("R1 clkMonRst in reset", clkMonRst, 0);
    rstN = 1'b1;
    step(1'b1);

    // R3: detector unarmed
    monEn = 1'b0;
    step(1'b1);
    check("R3 monArmed off", monArmed, 0);
    repeat (20) step(1'b0);
    check("R3 no limp when unarmed", limpHome, 0);
    check("R3 no request when unarmed", clkMonRst, 0);
    monEn = 1'b1;
    step(1'b1);
    check("R3 monArmed on", monArmed, 1);

    // R2: sweep gap length in both timeout modes
    for (int fm = 0; fm < 2; fm++) begin
      fastMonEn = (fm == 1);
      for (int g = 1; g <= 10; g++) begin
        step(1'b1);
        repeat (g) step(1'b0);
        check($sformatf("R2 gap %0d fast %0d", g, fm), limpHome,
              (g >= (fm == 1 ? TOF : TO)) ? 1 : 0);
        if (limpHome) begin
          check("R5 flag during recovery start", limpHome, 1);
          recoverCheck(OSC);
        end
      end
    end
    fastMonEn = 1'b0;

    // R4: limp-home forbidden
    noLimp = 1'b1;
    step(1'b1);
    repeat (TO) step(1'b0);
    check("R4 request pulse", clkMonRst, 1);
    check("R4 no limp", limpHome, 0);
    step(1'b0);
    check("R4 pulse one cycle", clkMonRst, 0);
    check("R4 still no limp", limpHome, 0);
    noLimp = 1'b0;
    step(1'b1);

    // R7: gap inside limp-home restarts the count
    step(1'b1);
    repeat (TO) step(1'b0);
    check("R7 entered", limpHome, 1);
    runTicks(2000);
    repeat (TO) step(1'b0);
    check("R7 limp kept across gap", limpHome, 1);
    recoverCheck(OSC);

    // R10: PLL engage, loss, cleared select during limp
    pllAuto = 1'b1; pllSel = 1'b1; pllLock = 1'b1;
    step(1'b1);
    check("R8 gated before PLL", sysSel, OFF);
    step(1'b1);
    check("R10 PLL engaged", sysSel, PLL);
    repeat (TO) step(1'b0);
    check("R5 limp entered from PLL", limpHome, 1);
    check("R8 PLL kept on entry edge", sysSel, PLL);
    step(1'b0);
    check("R8 gated on entry", sysSel, OFF);
    step(1'b0);
    check("R9 backup in limp", sysSel, BACKUP);
    pllSel = 1'b0;
    step(1'b0);
    check("R5 flag held after select cleared", limpHome, 1);
    recoverCheck(OSC);
    pllSel = 1'b1;
    step(1'b1);
    check("R8 gated before PLL again", sysSel, OFF);
    step(1'b1);
    check("R10 PLL after select restored", sysSel, PLL);

    // R10: saved auto+select resumes PLL
    repeat (TO) step(1'b0);
    check("R5 limp again", limpHome, 1);
    recoverCheck(PLL);

    // R10: no lock at exit, PLL taken once locked
    repeat (TO) step(1'b0);
    pllLock = 1'b0;
    recoverCheck(OSC);
    pllLock = 1'b1;
    step(1'b1);
    check("R8 gated on late lock", sysSel, OFF);
    step(1'b1);
    check("R10 PLL after late lock", sysSel, PLL);

    // concurrent: lock arrives in the cycle the loss is detected
    pllLock = 1'b0;
    step(1'b1);
    step(1'b1);
    check("R10 oscillator without lock", sysSel, OSC);
    step(1'b1);
    repeat (TO - 1) step(1'b0);
    pllLock = 1'b1;
    step(1'b0);
    check("R2 loss with lock edge", limpHome, 1);
    check("R8 gated on collision", sysSel, OFF);
    step(1'b0);
    check("R9 backup not PLL on collision", sysSel, BACKUP);
    recoverCheck(PLL);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule